// File: doc/BRIEF.md
# Chainable Eight-Input Serializer Stage

This block is the device side of one serializer stage for eight digital field inputs. Each input passes through a digital filter whose hold time is picked by a two-bit setting. When the chip select falls, the stage captures the filtered inputs, the health flags and the format pin. It then shifts a frame out over a mode 0 serial link.

A short frame carries only the input byte. A long frame carries the input byte followed by a status byte. In the status byte, a 5-bit CRC of the input byte sits in the upper bits and the health indications sit in the lower bits.

Bits that arrive on the serial input come out on the serial output once the stage's own word has gone, delayed by exactly one word length. Any number of stages can therefore be wired in a chain and read in one select period. A fault output follows the overtemperature and undervoltage-alarm flags.

All pins are sampled on the block clock through a synchronizer of `SYNC_STAGES` flops. The serial clock must therefore be slow against `clk_i`: each serial clock phase must last at least `SYNC_STAGES`+2 clock periods.

Top module: `inser_stage`

## Requirements
- R1: After reset, and whenever chip select is inactive, `sdo_o` is 0 and `fault_o` is 0 while no flag is raised.
- R2: With `mode8_i` low at select, the frame is 16 bits, most significant bit first. Frame bits 15:8 hold the filtered inputs, with `in_i[7]` first, and frame bits 7:0 hold the status byte.
- R3: Status bits 7:3 hold the CRC of the input byte. The CRC uses the generator x^5+x^4+x^2+1, is taken most significant bit first, and starts from 0.
- R4: Status bit 2 is the inverse of `uv_alarm_i`, status bit 1 equals `ovt_i`, and status bit 0 is the inverse of `uv_warn_i`.
- R5: With `mode8_i` high at select, the frame is the 8-bit input byte alone.
- R6: Inputs, flags and `mode8_i` are captured when chip select falls. Changes to them during the frame do not alter the bits shifted out.
- R7: The serial output changes after serial clock falling edges and the serial input is sampled on rising edges. After its own word, the stage outputs each serial input bit delayed by 8 bit times in short mode and 16 bit times in long mode.
- R8: `db_sel_i` codes 0, 1, 2 and 3 select filter hold times N of 1, `DB_SHORT`, `DB_MED` and `DB_LONG` clock periods. A new input level applied N periods before chip select falls is captured; one applied N-1 periods before is not.
- R9: An input pulse lasting N-1 clock periods never reaches the filtered value.
- R10: `fault_o` is high while `ovt_i` or `uv_alarm_i` is high, within `SYNC_STAGES`+1 clocks. `uv_warn_i` alone does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | block clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| in_i | input | 8 | raw field inputs |
| db_sel_i | input | 2 | filter hold-time select |
| mode8_i | input | 1 | high: 8-bit frame, low: 16-bit frame |
| ovt_i | input | 1 | overtemperature flag |
| uv_alarm_i | input | 1 | undervoltage alarm flag |
| uv_warn_i | input | 1 | undervoltage warning flag |
| cs_ni | input | 1 | chip select, active low |
| sck_i | input | 1 | serial clock, mode 0 |
| sdi_i | input | 1 | serial data from the upstream stage |
| sdo_o | output | 1 | serial data out |
| fault_o | output | 1 | fault indication |

## Verification
Every pin reaches the logic two clocks after it changes. A select fall therefore loads the frame on the third clock edge, and each serial clock edge takes effect on the third edge as well. The bench holds each serial clock phase for six clocks and samples `sdo_o` just before it raises the clock, after the output has settled. The filter boundary of R8 is checked by counting whole clock periods between the input step and the select fall: a latched result appears only when that gap reaches N. Fault is read at least four clocks after the flags change.

// File: rtl/inser_pkg.sv
package inser_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 5;
  localparam logic [CRC_W-1:0] CRC_GEN = 5'h15;  // x^5 + x^4 + x^2 + 1

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    DB_NONE  = 2'd0,
    DB_SHORT = 2'd1,
    DB_MED   = 2'd2,
    DB_LONG  = 2'd3
  } db_sel_e;

  function automatic logic [CRC_W-1:0] crc5(input byte_t d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_GEN;
    end
    return c;
  endfunction

  function automatic byte_t status_byte(input byte_t d, input logic ovt,
                                        input logic uva, input logic uvw);
    return {crc5(d), ~uva, ovt, ~uvw};
  endfunction
endpackage

// File: rtl/inser_sync.sv
module inser_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/inser_debounce.sv
module inser_debounce #(
  parameter int WIDTH = 8,
  parameter int LIM1  = 4,
  parameter int LIM2  = 16,
  parameter int LIM3  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] filt_o
);
  localparam int MAX12 = (LIM1 > LIM2) ? LIM1 : LIM2;
  localparam int MAXL  = (MAX12 > LIM3) ? MAX12 : LIM3;
  localparam int CW    = $clog2(MAXL + 1);

  logic [CW-1:0] lim_m1;

  always_comb begin
    unique case (sel_i)
      2'd1:    lim_m1 = CW'(LIM1 - 1);
      2'd2:    lim_m1 = CW'(LIM2 - 1);
      2'd3:    lim_m1 = CW'(LIM3 - 1);
      default: lim_m1 = '0;
    endcase
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [CW-1:0] cnt;
    logic          filt_q;

    // level flips only after N consecutive samples disagree with it
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt    <= '0;
        filt_q <= 1'b0;
      end else if (raw_i[g] == filt_q) begin
        cnt <= '0;
      end else if (cnt >= lim_m1) begin
        cnt    <= '0;
        filt_q <= raw_i[g];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign filt_o[g] = filt_q;
  end
endmodule

// File: rtl/inser_frame.sv
module inser_frame
  import inser_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_n_i,
  input  logic  sck_i,
  input  logic  sdi_i,
  input  byte_t data_i,
  input  logic  mode8_i,
  input  logic  ovt_i,
  input  logic  uva_i,
  input  logic  uvw_i,
  output logic  sdo_o,
  output logic  load_o,
  output logic  shift_o
);
  localparam int FRAME_W = 2 * BYTE_W;

  logic               cs_n_q, sck_q, sdi_q, mode8_q;
  logic [FRAME_W-1:0] sr;
  logic               sck_rise;

  assign load_o   = cs_n_q & ~cs_n_i;
  assign sck_rise = ~sck_q & sck_i & ~cs_n_i;
  assign shift_o  = sck_q & ~sck_i & ~cs_n_i & ~load_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      sdi_q   <= 1'b0;
      mode8_q <= 1'b0;
      sr      <= '0;
    end else begin
      cs_n_q <= cs_n_i;
      sck_q  <= sck_i;
      if (sck_rise) sdi_q <= sdi_i;
      if (load_o) begin
        mode8_q <= mode8_i;
        sr      <= mode8_i ? {{BYTE_W{1'b0}}, data_i}
                           : {data_i, status_byte(data_i, ovt_i, uva_i, uvw_i)};
      end else if (shift_o) begin
        sr <= {sr[FRAME_W-2:0], sdi_q};
      end
    end
  end

  // tap point sets the pass-through delay to one word length
  assign sdo_o = ~cs_n_i & (mode8_q ? sr[BYTE_W-1] : sr[FRAME_W-1]);
endmodule

// File: rtl/inser_stage.sv
module inser_stage
  import inser_pkg::*;
#(
  parameter int DB_SHORT    = 4,
  parameter int DB_MED      = 16,
  parameter int DB_LONG     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_i,
  input  logic [1:0] db_sel_i,
  input  logic       mode8_i,
  input  logic       ovt_i,
  input  logic       uv_alarm_i,
  input  logic       uv_warn_i,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       fault_o
);
  localparam int BUS_W = BYTE_W + 7;
  localparam logic [BUS_W-1:0] BUS_RST = BUS_W'(4);  // chip select idles high

  logic [BUS_W-1:0] pin_bus, sync_bus;
  byte_t raw_s, data_filt;
  logic  ovt_s, uva_s, uvw_s, mode8_s, cs_s, sck_s, sdi_s;
  logic  load, shift, fault_q;

  assign pin_bus = {in_i, ovt_i, uv_alarm_i, uv_warn_i, mode8_i, cs_ni, sck_i, sdi_i};

  inser_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_bus),
    .q_o   (sync_bus)
  );

  assign {raw_s, ovt_s, uva_s, uvw_s, mode8_s, cs_s, sck_s, sdi_s} = sync_bus;

  inser_debounce #(
    .WIDTH(BYTE_W),
    .LIM1 (DB_SHORT),
    .LIM2 (DB_MED),
    .LIM3 (DB_LONG)
  ) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (db_sel_i),
    .raw_i (raw_s),
    .filt_o(data_filt)
  );

  inser_frame u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_n_i (cs_s),
    .sck_i  (sck_s),
    .sdi_i  (sdi_s),
    .data_i (data_filt),
    .mode8_i(mode8_s),
    .ovt_i  (ovt_s),
    .uva_i  (uva_s),
    .uvw_i  (uvw_s),
    .sdo_o  (sdo_o),
    .load_o (load),
    .shift_o(shift)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= ovt_s | uva_s;
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/inser_stage_chk.sv
module inser_stage_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       cs_s,
  input logic       sdo_o,
  input logic       fault_o,
  input logic       load,
  input logic       shift,
  input logic [7:0] raw_s,
  input logic [7:0] data_filt,
  input logic       ovt_s,
  input logic       uva_s
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> !sdo_o);

  // R2
  data_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !cs_ni) |=> (cs_s || sdo_o == $past(data_filt[7])));

  // R6
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && $past(!cs_s) && !$past(load) && !$past(shift)) |-> $stable(sdo_o));

  // R9
  filt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_filt) |-> ($past(raw_s) != $past(data_filt)));

  // R10
  fault_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> (!$past(ovt_s) && !$past(uva_s)));
endmodule

bind inser_stage inser_stage_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .cs_s     (cs_s),
  .sdo_o    (sdo_o),
  .fault_o  (fault_o),
  .load     (load),
  .shift    (shift),
  .raw_s    (raw_s),
  .data_filt(data_filt),
  .ovt_s    (ovt_s),
  .uva_s    (uva_s)
);

// File: tb/inser_stage_test.sv
`timescale 1ns/1ps
module inser_stage_test;
  localparam int DBS = 4;
  localparam int DBM = 16;
  localparam int DBL = 64;
  localparam int WDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_v = '0;
  logic [1:0] db_sel = '0;
  logic       mode8 = 1'b0, ovt = 1'b0, uva = 1'b0, uvw = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic       sdo, fault;
  logic [31:0] rr;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  inser_stage #(.DB_SHORT(DBS), .DB_MED(DBM), .DB_LONG(DBL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .db_sel_i(db_sel), .mode8_i(mode8),
    .ovt_i(ovt), .uv_alarm_i(uva), .uv_warn_i(uvw), .cs_ni(cs_n), .sck_i(sck),
    .sdi_i(sdi), .sdo_o(sdo), .fault_o(fault)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<%0d cycles", cycles, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // remainder of d*x^5 divided by x^5+x^4+x^2+1
  function automatic logic [4:0] crc_ref(input logic [7:0] d);
    logic [12:0] v;
    v = {d, 5'b0};
    for (int b = 12; b >= 5; b--)
      if (v[b]) v = v ^ (13'(6'b110101) << (b - 5));
    return v[4:0];
  endfunction

  function automatic int lim(input int s);
    return (s == 0) ? 1 : (s == 1) ? DBS : (s == 2) ? DBM : DBL;
  endfunction

  task automatic xfer(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      dout[i] = sdo;
      sdi = din[i];
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
      repeat (6) @(negedge clk);
    end
    cs_n = 1'b1;
    sdi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 sdo idle", 32'(sdo), 32'd0);
    check("R1 fault idle", 32'(fault), 32'd0);

    // long frames, every input byte, all flag combinations
    for (int d = 0; d < 256; d++) begin
      in_v = 8'(d);
      ovt = d[3]; uva = d[6]; uvw = d[1];
      repeat (4) @(negedge clk);
      xfer(16, 32'd0, rr);
      check("R2 data byte", 32'(rr[15:8]), 32'(d));
      check("R3 crc", 32'(rr[7:3]), 32'(crc_ref(8'(d))));
      check("R4 health bits", 32'(rr[2:0]), 32'({~d[6], d[3], ~d[1]}));
      check("R10 fault", 32'(fault), 32'(d[3] | d[6]));
      check("R1 sdo idle after frame", 32'(sdo), 32'd0);
    end
    ovt = 0; uva = 0; uvw = 0;

    // short frames
    mode8 = 1'b1;
    for (int d = 0; d < 256; d++) begin
      in_v = 8'(d ^ 8'h5a);
      repeat (4) @(negedge clk);
      xfer(8, 32'd0, rr);
      check("R5 short frame", 32'(rr[7:0]), 32'(d ^ 8'h5a));
    end

    // chain pass-through
    mode8 = 1'b0; in_v = 8'ha5;
    repeat (4) @(negedge clk);
    xfer(32, {16'h3c96, 16'h0}, rr);
    check("R7 long own byte", 32'(rr[31:24]), 32'h a5);
    check("R7 long forward", 32'(rr[15:0]), 32'h3c96);
    mode8 = 1'b1;
    repeat (4) @(negedge clk);
    xfer(24, {8'h0, 16'hc35a, 8'h0}, rr);
    check("R7 short own byte", 32'(rr[23:16]), 32'ha5);
    check("R7 short forward", 32'(rr[15:0]), 32'hc35a);

    // capture at select fall
    mode8 = 1'b0; in_v = 8'h0f;
    repeat (4) @(negedge clk);
    fork
      xfer(16, 32'd0, rr);
      begin
        repeat (20) @(negedge clk);
        in_v = 8'hf0; ovt = 1'b1; uva = 1'b1; mode8 = 1'b1;
      end
    join
    check("R6 frame held", 32'(rr[15:0]), 32'({8'h0f, crc_ref(8'h0f), 3'b101}));
    ovt = 0; uva = 0; mode8 = 1'b1; in_v = 8'h00;

    // filter boundary for each setting
    for (int s = 0; s < 4; s++) begin
      db_sel = 2'(s);
      in_v = 8'h00;
      repeat (2 * lim(s) + 10) @(negedge clk);
      in_v[0] = 1'b1;
      repeat (lim(s) - 1) @(negedge clk);
      xfer(8, 32'd0, rr);
      check($sformatf("R8 sel%0d step N-1", s), 32'(rr[0]), 32'd0);
      in_v = 8'h00;
      repeat (2 * lim(s) + 10) @(negedge clk);
      in_v[0] = 1'b1;
      repeat (lim(s)) @(negedge clk);
      xfer(8, 32'd0, rr);
      check($sformatf("R8 sel%0d step N", s), 32'(rr[0]), 32'd1);
      in_v = 8'h00;
      repeat (2 * lim(s) + 10) @(negedge clk);
      if (s > 0) begin
        in_v[1] = 1'b1;
        repeat (lim(s) - 1) @(negedge clk);
        in_v[1] = 1'b0;
        xfer(8, 32'd0, rr);
        check($sformatf("R9 sel%0d glitch", s), 32'(rr[1]), 32'd0);
        repeat (2 * lim(s) + 10) @(negedge clk);
      end
    end

    // warning alone, then alarm release
    uvw = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 warn alone", 32'(fault), 32'd0);
    uva = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 alarm", 32'(fault), 32'd1);
    uva = 1'b0; uvw = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 release", 32'(fault), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule